// File: doc/BRIEF.md
# Boot Mode Stream Translator and Reset Sequencer

This block runs the power-up sequence of a processor placed behind a board that expects an older processor's boot protocol. Once the supply-good input rises, it produces a slow serial mode clock by dividing the system clock. It samples the board's serial boot-mode word on that clock and relays the word to the processor. On the way it rewrites a few configuration fields.

The transmit data pattern field is always replaced by a fixed code. The byte-order bit and the secondary-cache-enable bit are not passed on. They are latched and presented on dedicated outputs, and a zero is sent in their place. Every other bit is passed through unchanged. Forwarding stops when the whole word has been sent or when the board releases its warm reset, whichever comes first.

The same block sequences the processor's two active-low resets. Cold reset is released once the PLL reports lock and the board's cold reset is released. Warm reset follows the board's warm reset, but it is held until the configuration-done flag is present. If that flag arrives late, warm reset is released on the next rising edge of the mode clock. Supply-good low resets the block asynchronously. All releases are synchronous to the system clock.

Top module: `bootseq_top`

## Requirements
- R1: The mode clock has a period of DIV system clock cycles (DIV a power of two). It is low for the first DIV/2 cycles after supply-good rises and high for the next DIV/2, so its first rising edge comes DIV/2 cycles after supply-good rises.
- R2: While supply-good is low, all outputs are 0: mode clock, mode data, both processor resets (asserted) and both latched bits.
- R3: While the board holds warm reset low, mode_in is sampled at each rising edge of the mode clock. The k-th sample (k = 0 first) is bit LEN-1-k of the mode word, so the word is sent MSB first. Its forwarded value appears on mode_out at the following falling edge and holds until the next falling edge.
- R4: Bits outside the rewritten positions are forwarded unchanged.
- R5: Bits XPAT_LSB to XPAT_LSB+XPAT_W-1 form the pattern field. Bit number XPAT_LSB+i is forwarded as bit i of XPAT_CODE, whatever the input is.
- R6: Bit ENDIAN_BIT and bit SCEN_BIT are forwarded as 0. The sampled values appear on held_endian and held_scen and are kept until supply-good drops.
- R7: After LEN samples, or once the board's warm reset is high at a rising edge of the mode clock, no further bit is sampled and mode_out is 0 from the next falling edge on.
- R8: cpu_cold_n goes high one clock after pll_locked and board_cold_n are both high. It goes low one clock after either of them drops.
- R9: When cfg_done is already high and cpu_cold_n is high, cpu_warm_n goes high one clock after board_warm_n goes high.
- R10: If cfg_done is low when the board releases warm reset, cpu_warm_n stays low. It rises in the clock in which the mode clock next rises after cfg_done is set.
- R11: cpu_warm_n goes low one clock after board_warm_n falls or after the cold-release condition drops. It is never high while cpu_cold_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System master clock |
| pwr_ok | input | 1 | Supply good; low resets the block asynchronously |
| board_cold_n | input | 1 | Board cold reset, active low |
| board_warm_n | input | 1 | Board warm reset, active low; low enables mode-word shifting |
| mode_in | input | 1 | Serial boot-mode data from the board |
| cfg_done | input | 1 | Programmable logic configuration complete |
| pll_locked | input | 1 | Clock multiplier reports lock |
| mode_clk | output | 1 | Serial mode clock, system clock divided by DIV |
| mode_out | output | 1 | Rewritten serial mode data toward the processor |
| cpu_cold_n | output | 1 | Processor cold reset, active low |
| cpu_warm_n | output | 1 | Processor warm reset, active low |
| held_endian | output | 1 | Latched byte-order bit taken out of the stream |
| held_scen | output | 1 | Latched secondary-cache-enable bit taken out of the stream |

## Verification
A divider that is off by one shows at the very first mode-clock rise, which comes early or late against the DIV/2 count, and again in every later period. A wrong position counter or a wrong field index shows within one mode-clock period on mode_out: a forced field bit or a stripped bit follows the input, or a data bit is shifted into the wrong slot. A latch-selection error shows on the held outputs once the word ends. A stuck or premature release state in the sequencer shows within one system clock of the triggering input edge. In the late-configuration case it shows as a release that is not aligned with a mode-clock rise.

// File: rtl/bootseq_pkg.sv
package bootseq_pkg;

  typedef enum logic [1:0] {
    FLD_PASS  = 2'd0,
    FLD_FORCE = 2'd1,
    FLD_STRIP = 2'd2
  } fld_kind_e;

  // Decide how a bit number of the mode word is treated on the way out.
  function automatic fld_kind_e classify(input int bitnum, input int xpat_lsb,
                                         input int xpat_w, input int endian_bit,
                                         input int scen_bit);
    if (bitnum == endian_bit || bitnum == scen_bit) return FLD_STRIP;
    if (bitnum >= xpat_lsb && bitnum < xpat_lsb + xpat_w) return FLD_FORCE;
    return FLD_PASS;
  endfunction

  // Value actually forwarded for one bit.
  function automatic logic fwd_value(input fld_kind_e kind, input logic din,
                                     input logic [31:0] code, input int bitnum,
                                     input int xpat_lsb);
    logic [31:0] sh;
    sh = code >> (bitnum - xpat_lsb);
    case (kind)
      FLD_FORCE: return sh[0];
      FLD_STRIP: return 1'b0;
      default:   return din;
    endcase
  endfunction

endpackage

// File: rtl/bootseq_clkdiv.sv
module bootseq_clkdiv #(
  parameter int DIV = 256
) (
  input  logic clk,
  input  logic rst_n,
  output logic mode_clk,
  output logic rise_ev,
  output logic fall_ev
);
  localparam int CW   = $clog2(DIV);
  localparam int HALF = DIV / 2;

  logic [CW-1:0] div_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_cnt <= '0;
    else        div_cnt <= div_cnt + 1'b1;
  end

  assign mode_clk = div_cnt[CW-1];
  assign rise_ev  = (div_cnt == CW'(HALF - 1));
  assign fall_ev  = (div_cnt == CW'(DIV - 1));

  // high-phase length monitor
  logic [CW:0] hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hi_run <= '0;
    else if (mode_clk) hi_run <= hi_run + 1'b1;
    else               hi_run <= '0;
  end

  // R1
  half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_clk) |-> hi_run == (CW+1)'(HALF));

  // R1
  edge_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev |=> $rose(mode_clk));

endmodule

// File: rtl/bootseq_stream.sv
module bootseq_stream
  import bootseq_pkg::*;
#(
  parameter int          LEN        = 256,
  parameter int          XPAT_LSB   = 1,
  parameter int          XPAT_W     = 4,
  parameter logic [31:0] XPAT_CODE  = 32'h0,
  parameter int          ENDIAN_BIT = 8,
  parameter int          SCEN_BIT   = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_ev,
  input  logic fall_ev,
  input  logic shift_en,
  input  logic mode_in,
  output logic mode_out,
  output logic held_endian,
  output logic held_scen
);
  localparam int PW = $clog2(LEN + 1);

  logic [PW-1:0] pos;
  logic          in_bit;
  logic          in_valid;
  int            bitnum;
  fld_kind_e     kind;
  logic          fwd_bit;
  logic          pos_open;

  assign pos_open = (pos < PW'(LEN));
  assign bitnum   = LEN - 1 - int'(pos);
  assign kind     = classify(bitnum, XPAT_LSB, XPAT_W, ENDIAN_BIT, SCEN_BIT);
  assign fwd_bit  = fwd_value(kind, in_bit, XPAT_CODE, bitnum, XPAT_LSB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos         <= '0;
      in_bit      <= 1'b0;
      in_valid    <= 1'b0;
      mode_out    <= 1'b0;
      held_endian <= 1'b0;
      held_scen   <= 1'b0;
    end else if (rise_ev) begin
      if (shift_en && pos_open) begin
        in_valid <= 1'b1;
        in_bit   <= mode_in;
        if (bitnum == ENDIAN_BIT) held_endian <= mode_in;
        if (bitnum == SCEN_BIT)   held_scen   <= mode_in;
      end else begin
        in_valid <= 1'b0;
      end
    end else if (fall_ev) begin
      mode_out <= in_valid ? fwd_bit : 1'b0;
      if (in_valid) pos <= pos + 1'b1;
      in_valid <= 1'b0;
    end
  end

  // R3
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_ev |=> $stable(mode_out));

  // R7
  pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= PW'(LEN));

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_ev && !pos_open && !in_valid) |=> !mode_out);

  // R6
  held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_ev |=> $stable(held_endian) && $stable(held_scen));

endmodule

// File: rtl/bootseq_rstseq.sv
module bootseq_rstseq (
  input  logic clk,
  input  logic rst_n,
  input  logic board_cold_n,
  input  logic board_warm_n,
  input  logic pll_locked,
  input  logic cfg_done,
  input  logic rise_ev,
  output logic cpu_cold_n,
  output logic cpu_warm_n
);
  logic cold_ok;
  logic late_q;

  assign cold_ok = pll_locked & board_cold_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_cold_n <= 1'b0;
      cpu_warm_n <= 1'b0;
      late_q     <= 1'b0;
    end else begin
      cpu_cold_n <= cold_ok;
      if (!board_warm_n || !cold_ok || !cpu_cold_n) begin
        cpu_warm_n <= 1'b0;
        late_q     <= 1'b0;
      end else if (!cpu_warm_n) begin
        if (cfg_done && (!late_q || rise_ev)) cpu_warm_n <= 1'b1;
        else if (!cfg_done)                   late_q     <= 1'b1;
      end
    end
  end

  // R8
  cold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_cold_n) |-> $past(pll_locked) && $past(board_cold_n));

  // R11
  warm_under_cold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_warm_n |-> cpu_cold_n);

  // R9
  warm_needs_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_warm_n) |-> $past(cfg_done) && $past(board_warm_n));

  // R10
  late_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cpu_warm_n) && $past(late_q)) |-> $past(rise_ev));

endmodule

// File: rtl/bootseq_top.sv
module bootseq_top #(
  parameter int          DIV        = 256,
  parameter int          LEN        = 256,
  parameter int          XPAT_LSB   = 1,
  parameter int          XPAT_W     = 4,
  parameter logic [31:0] XPAT_CODE  = 32'h0,
  parameter int          ENDIAN_BIT = 8,
  parameter int          SCEN_BIT   = 12
) (
  input  logic clk,
  input  logic pwr_ok,
  input  logic board_cold_n,
  input  logic board_warm_n,
  input  logic mode_in,
  input  logic cfg_done,
  input  logic pll_locked,
  output logic mode_clk,
  output logic mode_out,
  output logic cpu_cold_n,
  output logic cpu_warm_n,
  output logic held_endian,
  output logic held_scen
);
  logic rise_ev;
  logic fall_ev;

  bootseq_clkdiv #(.DIV(DIV)) clkdiv_i (
    .clk      (clk),
    .rst_n    (pwr_ok),
    .mode_clk (mode_clk),
    .rise_ev  (rise_ev),
    .fall_ev  (fall_ev)
  );

  bootseq_stream #(
    .LEN        (LEN),
    .XPAT_LSB   (XPAT_LSB),
    .XPAT_W     (XPAT_W),
    .XPAT_CODE  (XPAT_CODE),
    .ENDIAN_BIT (ENDIAN_BIT),
    .SCEN_BIT   (SCEN_BIT)
  ) stream_i (
    .clk         (clk),
    .rst_n       (pwr_ok),
    .rise_ev     (rise_ev),
    .fall_ev     (fall_ev),
    .shift_en    (!board_warm_n),
    .mode_in     (mode_in),
    .mode_out    (mode_out),
    .held_endian (held_endian),
    .held_scen   (held_scen)
  );

  bootseq_rstseq rstseq_i (
    .clk          (clk),
    .rst_n        (pwr_ok),
    .board_cold_n (board_cold_n),
    .board_warm_n (board_warm_n),
    .pll_locked   (pll_locked),
    .cfg_done     (cfg_done),
    .rise_ev      (rise_ev),
    .cpu_cold_n   (cpu_cold_n),
    .cpu_warm_n   (cpu_warm_n)
  );

  // R2
  reset_quiet_chk: assert property (@(posedge clk)
    !pwr_ok |-> !mode_clk && !mode_out && !cpu_cold_n && !cpu_warm_n);

endmodule

// File: tb/bootseq_tb.sv
module bootseq_top_tb_top;
  localparam int          T_DIV  = 8;
  localparam int          T_LEN  = 16;
  localparam int          T_XLSB = 1;
  localparam int          T_XW   = 4;
  localparam logic [31:0] T_CODE = 32'hA;
  localparam int          T_END  = 8;
  localparam int          T_SCEN = 12;

  logic clk = 1'b0;
  logic pwr_ok = 1'b0, board_cold_n = 1'b0, board_warm_n = 1'b0;
  logic mode_in = 1'b0, cfg_done = 1'b0, pll_locked = 1'b0;
  logic mode_clk, mode_out, cpu_cold_n, cpu_warm_n, held_endian, held_scen;

  int nvec = 0;
  int nbad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  bootseq_top #(
    .DIV(T_DIV), .LEN(T_LEN), .XPAT_LSB(T_XLSB), .XPAT_W(T_XW),
    .XPAT_CODE(T_CODE), .ENDIAN_BIT(T_END), .SCEN_BIT(T_SCEN)
  ) dut_i (
    .clk(clk), .pwr_ok(pwr_ok), .board_cold_n(board_cold_n),
    .board_warm_n(board_warm_n), .mode_in(mode_in), .cfg_done(cfg_done),
    .pll_locked(pll_locked), .mode_clk(mode_clk), .mode_out(mode_out),
    .cpu_cold_n(cpu_cold_n), .cpu_warm_n(cpu_warm_n),
    .held_endian(held_endian), .held_scen(held_scen)
  );

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // Expected forwarded value, written from the requirement text.
  function automatic int exp_bit(input int bn, input int din);
    if (bn == T_END || bn == T_SCEN) return 0;                    // R6
    if (bn >= T_XLSB && bn <= T_XLSB + T_XW - 1)
      return int'((T_CODE / (32'd1 << (bn - T_XLSB))) % 2);       // R5
    return din;                                                   // R4
  endfunction

  function automatic string tag_of(input int bn);
    if (bn == T_END || bn == T_SCEN) return "R6";
    if (bn >= T_XLSB && bn <= T_XLSB + T_XW - 1) return "R5";
    return "R4";
  endfunction

  task automatic quiet_check();
    chk("R2 mode_clk", int'(mode_clk), 0);
    chk("R2 mode_out", int'(mode_out), 0);
    chk("R2 cpu_cold_n", int'(cpu_cold_n), 0);
    chk("R2 cpu_warm_n", int'(cpu_warm_n), 0);
    chk("R2 held", int'(held_endian) + int'(held_scen), 0);
  endtask

  task automatic run_stream(input logic [15:0] pat, input int stop_after);
    int nsamp, r, cyc, last_rise, k, bn;
    logic prev, mc;
    nsamp = (stop_after < T_LEN) ? stop_after : T_LEN;
    @(negedge clk);
    pwr_ok = 1'b0; board_warm_n = 1'b0; mode_in = pat[T_LEN-1];
    @(negedge clk); #1;
    quiet_check();
    @(negedge clk);
    pwr_ok = 1'b1;
    r = 0; cyc = 0; last_rise = 0; prev = 1'b0;
    while (r < T_LEN + 3) begin
      @(negedge clk);
      cyc++;
      mc = mode_clk;
      if (mc && !prev) begin
        chk("R1 period", cyc - last_rise, (r == 0) ? T_DIV / 2 : T_DIV);
        last_rise = cyc;
        if (r >= 1 && r - 1 < nsamp) begin
          k = r - 1; bn = T_LEN - 1 - k;
          chk({"R3 ", tag_of(bn)}, int'(mode_out), exp_bit(bn, int'(pat[bn])));
        end else begin
          chk("R7 idle out", int'(mode_out), 0);
        end
        r++;
      end else if (!mc && prev) begin
        if (r == stop_after) board_warm_n = 1'b1;
        mode_in = (r < T_LEN) ? pat[T_LEN-1-r] : 1'b1;
      end
      prev = mc;
    end
    bn = T_END;
    chk("R6 held_endian", int'(held_endian), (T_LEN-1-bn < nsamp) ? int'(pat[bn]) : 0);
    bn = T_SCEN;
    chk("R6 held_scen", int'(held_scen), (T_LEN-1-bn < nsamp) ? int'(pat[bn]) : 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      nbad++; nvec++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    bit early;
    logic prev;
    #1;
    quiet_check();   // R2 at start

    // stream sweeps: R1, R3, R4, R5, R6, R7
    for (int i = 0; i < T_LEN; i++) run_stream(16'h1 << i, 99);
    run_stream(16'h0000, 99);
    run_stream(16'hFFFF, 99);
    run_stream(16'hA5C3, 99);
    run_stream(16'h5A3C, 99);
    run_stream(16'hFFFF, 5);    // R7 early stop
    run_stream(16'hEFFF, 9);    // R7 stop after scen bit

    // reset sequencing
    @(negedge clk);
    board_warm_n = 1'b0; cfg_done = 1'b1; pll_locked = 1'b1; board_cold_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 cold held by board", int'(cpu_cold_n), 0);
    board_cold_n = 1'b1;
    #1 chk("R8 cold before edge", int'(cpu_cold_n), 0);
    @(negedge clk);
    chk("R8 cold release", int'(cpu_cold_n), 1);
    repeat (2) @(negedge clk);
    chk("R11 warm held by board", int'(cpu_warm_n), 0);
    board_warm_n = 1'b1;
    @(negedge clk);
    chk("R9 warm with board", int'(cpu_warm_n), 1);
    board_warm_n = 1'b0;
    @(negedge clk);
    chk("R11 warm reassert", int'(cpu_warm_n), 0);

    // late configuration: R10
    cfg_done = 1'b0;
    @(negedge clk);
    board_warm_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R10 held without cfg", int'(cpu_warm_n), 0);
    cfg_done = 1'b1;
    early = 1'b0;
    prev = mode_clk;
    for (int n = 0; n < 2 * T_DIV; n++) begin
      @(negedge clk);
      if (mode_clk && !prev) begin
        chk("R10 release on mode rise", int'(cpu_warm_n), 1);
        break;
      end
      if (cpu_warm_n) early = 1'b1;
      prev = mode_clk;
    end
    chk("R10 no early release", int'(early), 0);

    pll_locked = 1'b0;
    @(negedge clk);
    chk("R8 cold on lock loss", int'(cpu_cold_n), 0);
    chk("R11 warm on lock loss", int'(cpu_warm_n), 0);

    pwr_ok = 1'b0;
    #1 quiet_check();   // R2

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule